// File: doc/BRIEF.md
# Four-Step Transform Twiddle Correction Unit

This block sits between the column pass and the row pass of a four-step number-theoretic transform. The transform has length N = R×R, and its data is viewed as an R×R matrix. The unit accepts a stream of field elements in row-major order, so element k sits at row i = k / R and column j = k mod R. It multiplies each element by w^(i·j), where w is a primitive N-th root of unity, and it returns the corrected elements in the order they arrived. The field is the prime p = 2^64 − 2^32 + 1.

The unit stores no table of powers. A generator holds two values: the running twiddle of the current row and the per-row step w^i. Each accepted element advances the twiddle by one multiplication with the step. Each new row advances the step by one multiplication with w and resets the twiddle to 1. The datapath multiplication is pipelined, so the unit takes one element per clock. A stall at the output freezes the whole pipe, and no element is lost or repeated. Row and column positions come from the order of the stream and wrap after R×R elements, so consecutive matrices can be streamed back to back.

Top module: `twf_correct`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1, and the first accepted element takes matrix position (0, 0).
- R2: An element accepted as the k-th of a matrix leaves as (x · w^(i·j)) mod p, with i = k / R and j = k mod R.
- R3: Elements of row 0 or column 0 use a multiplier of 1, so a canonical input (below p) leaves unchanged.
- R4: out_data is always below p, including when the input value is p or larger (for example 2^64−1 at position (0,0) leaves as 2^32−2).
- R5: With out_ready held at 1, an element accepted at one clock edge is presented on out_data exactly 3 clock edges later.
- R6: While out_ready is 1, in_ready is 1 every cycle, so the unit sustains one element per clock.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value in the next cycle. Output order equals input order, with no loss and no duplication.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0.
- R9: After R×R accepted elements the position returns to (0, 0), and the next matrix is corrected from its own row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Unit accepts an element this cycle |
| in_data | input | 64 | Field element in row-major order |
| out_valid | output | 1 | Corrected element present |
| out_ready | input | 1 | Downstream accepts the output this cycle |
| out_data | output | 64 | Corrected field element, below p |

## Verification
The bench builds the unit with a matrix side of 4 (LOG_R = 2) and w = 4096. Because 2^96 ≡ −1 mod p, the value 4096 = 2^12 is a primitive 16th root of unity. With this small size, every row and column, the row-step update and the wrap into a second and third matrix all appear within a few dozen elements. The expected values come from plain exponentiation and 128-bit remainder arithmetic. Separate phases cover free flow (latency and throughput), irregular valid and ready patterns, and a long output stall that fills the pipe.

// File: rtl/twf_pkg.sv
package twf_pkg;

    localparam int unsigned FW      = 64;
    localparam int unsigned MUL_LAT = 3;
    localparam logic [63:0] FIELD_P = 64'hFFFF_FFFF_0000_0001;
    localparam logic [63:0] EPS     = 64'h0000_0000_FFFF_FFFF;

    // First fold: x = lo + a*2^64 + b*2^96, with 2^64 == EPS and 2^96 == -1.
    // The result lies below 3*2^64 and is congruent to x.
    function automatic logic [65:0] fold_hi(input logic [127:0] x);
        logic [63:0] a_eps;
        logic [65:0] acc;
        a_eps = {32'b0, x[95:64]} * EPS;
        acc   = {2'b0, x[63:0]} + {2'b0, a_eps} + {2'b0, FIELD_P}
              - {34'b0, x[127:96]};
        return acc;
    endfunction

    // Second fold plus one conditional subtraction gives the canonical value.
    function automatic logic [63:0] fold_lo(input logic [65:0] v);
        logic [64:0] t;
        t = {1'b0, v[63:0]} + ({63'b0, v[65:64]} * {1'b0, EPS});
        if (t >= {1'b0, FIELD_P}) begin
            t = t - {1'b0, FIELD_P};
        end
        return t[63:0];
    endfunction

    function automatic logic [63:0] modmul(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] pr;
        pr = {64'b0, a} * {64'b0, b};
        return fold_lo(fold_hi(pr));
    endfunction

endpackage

// File: rtl/twf_gen.sv
module twf_gen
    import twf_pkg::*;
#(
    parameter int unsigned LOG_R = 2,
    parameter logic [63:0] ROOT  = 64'd4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [FW-1:0] tw
);
    localparam int unsigned IW = (LOG_R < 1) ? 1 : LOG_R;
    localparam logic [IW-1:0] LAST = IW'((1 << LOG_R) - 1);

    typedef struct packed {
        logic [IW-1:0] col;
        logic [IW-1:0] row;
        logic [FW-1:0] twd;
        logic [FW-1:0] step;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.col == LAST) begin
                st_d.col = '0;
                st_d.twd = 64'd1;
                if (st_q.row == LAST) begin
                    st_d.row  = '0;
                    st_d.step = 64'd1;
                end else begin
                    st_d.row  = st_q.row + 1'b1;
                    st_d.step = modmul(st_q.step, ROOT);
                end
            end else begin
                st_d.col = st_q.col + 1'b1;
                st_d.twd = modmul(st_q.twd, st_q.step);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{col: '0, row: '0, twd: 64'd1, step: 64'd1};
        end else begin
            st_q <= st_d;
        end
    end

    assign tw = st_q.twd;

    // R3: the first row and the first column use a multiplier of 1
    p_row0_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.row == '0) |-> (st_q.twd == 64'd1));
    p_col0_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.col == '0) |-> (st_q.twd == 64'd1));
    // R9: the last element of a matrix returns the position to the origin
    p_matrix_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && st_q.row == LAST && st_q.col == LAST) |=> (st_q.row == '0 && st_q.col == '0));
    // R2: the twiddle stays canonical
    p_tw_canon_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.twd < FIELD_P);

endmodule

// File: rtl/twf_mulpipe.sv
module twf_mulpipe
    import twf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          in_vld,
    input  logic [FW-1:0] a,
    input  logic [FW-1:0] b,
    output logic          out_vld,
    output logic [FW-1:0] out_res
);
    typedef struct packed {
        logic         v1;
        logic [127:0] prod;
        logic         v2;
        logic [65:0]  part;
        logic         v3;
        logic [63:0]  res;
    } pipe_t;

    pipe_t pp_d, pp_q;

    always_comb begin
        pp_d = pp_q;
        if (en) begin
            pp_d.v1   = in_vld;
            pp_d.prod = {64'b0, a} * {64'b0, b};
            pp_d.v2   = pp_q.v1;
            pp_d.part = fold_hi(pp_q.prod);
            pp_d.v3   = pp_q.v2;
            pp_d.res  = fold_lo(pp_q.part);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_q <= '0;
        end else begin
            pp_q <= pp_d;
        end
    end

    assign out_vld = pp_q.v3;
    assign out_res = pp_q.res;

    // R5: three enabled edges carry an element from input to output
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_vld) ##1 en ##1 en |=> out_vld);

endmodule

// File: rtl/twf_correct.sv
module twf_correct
    import twf_pkg::*;
#(
    parameter int unsigned LOG_R = 2,
    parameter logic [63:0] ROOT  = 64'd4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [FW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [FW-1:0] out_data
);
    logic          advance;
    logic          accept;
    logic [FW-1:0] tw;

    assign advance  = !out_valid || out_ready;
    assign in_ready = advance;
    assign accept   = in_valid && advance;

    twf_gen #(
        .LOG_R (LOG_R),
        .ROOT  (ROOT)
    ) gen_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (accept),
        .tw    (tw)
    );

    twf_mulpipe mul_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (advance),
        .in_vld  (in_valid),
        .a       (in_data),
        .b       (tw),
        .out_vld (out_valid),
        .out_res (out_data)
    );

    // R4: every presented result is canonical
    p_out_canon_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data < FIELD_P));
    // R7: a stalled output is held
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R8: a stalled output blocks the input
    p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    // R6: a free output lets the input flow
    p_flow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);

endmodule

// File: tb/twf_correct_tb_top.sv
module twf_correct_tb_top;
    localparam int unsigned LOG_R = 2;
    localparam int unsigned R     = 1 << LOG_R;
    localparam int unsigned NN    = R * R;
    localparam logic [63:0] ROOT  = 64'd4096;
    localparam logic [127:0] PW   = 128'hFFFF_FFFF_0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;

    always #5 clk = ~clk;

    twf_correct #(.LOG_R(LOG_R), .ROOT(ROOT)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int n_run  = 0;
    int n_fail = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];
    int          stamp_q[$];
    bit          latchk_q[$];

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mmul(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] t;
        t = ({64'b0, a} * {64'b0, b}) % PW;
        return t[63:0];
    endfunction

    function automatic logic [63:0] powr(input int e);
        logic [63:0] acc;
        acc = 64'd1;
        for (int n = 0; n < e; n++) acc = mmul(acc, ROOT);
        return acc;
    endfunction

    int          cyc = 0;
    int          sent = 0;
    int          got = 0;
    int          stall_cnt = 0;
    logic [63:0] lcg = 64'h1234_5678_9ABC_DEF1;
    logic [7:0]  lfsr = 8'hA5;
    bit          prev_stall = 0;
    logic [63:0] prev_data = '0;

    // Driver: pushes the expected value of every accepted element
    task automatic drive_cycle();
        int k, i, j;
        string tg;
        logic [63:0] x;
        if (in_valid && in_ready) begin
            k = sent % NN;
            i = k / R;
            j = k % R;
            x = in_data;
            if (sent == 0)               tg = "R4";
            else if (sent >= NN && sent < 2 * NN) tg = "R9";
            else if (i == 0 || j == 0)   tg = "R3";
            else                         tg = "R2";
            exp_q.push_back(mmul(x, powr((i * j) % NN)));
            tag_q.push_back(tg);
            stamp_q.push_back(cyc);
            latchk_q.push_back(sent < 13);
            sent++;
        end
    endtask

    // Monitor: compares every transferred result with the scoreboard
    task automatic monitor_cycle();
        if (prev_stall) begin
            check(out_valid == 1'b1 && out_data == prev_data, "R7", out_data, prev_data);
        end
        if (out_valid && !out_ready) begin
            check(in_ready == 1'b0, "R8", {63'b0, in_ready}, 64'd0);
        end
        if (out_ready) begin
            check(in_ready == 1'b1, "R6", {63'b0, in_ready}, 64'd1);
        end
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", out_data, 64'd0);
            end else begin
                logic [63:0] e;
                string tg;
                int st;
                bit lc;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                st = stamp_q.pop_front();
                lc = latchk_q.pop_front();
                check(out_data == e, tg, out_data, e);
                check(out_data < 64'hFFFF_FFFF_0000_0001, "R4", out_data, e);
                if (lc) check(cyc - st == 3, "R5", 64'(cyc - st), 64'd3);
                got++;
            end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(out_valid == 1'b0, "R1", {63'b0, out_valid}, 64'd0);
        check(in_ready == 1'b1, "R1", {63'b0, in_ready}, 64'd1);

        while (!(sent >= 3 * NN && exp_q.size() == 0)) begin
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            lcg  = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            if (sent < NN) begin
                out_ready = 1'b1;
                in_valid  = 1'b1;
            end else if (sent < 2 * NN + 4) begin
                out_ready = lfsr[1] | lfsr[2];
                in_valid  = lfsr[0] | lfsr[6];
            end else if (stall_cnt < 6) begin
                out_ready = 1'b0;
                in_valid  = 1'b1;
                stall_cnt++;
            end else begin
                out_ready = 1'b1;
                in_valid  = (sent < 3 * NN);
            end
            if (sent == 0)      in_data = 64'hFFFF_FFFF_FFFF_FFFF;
            else if (sent == 5) in_data = 64'hFFFF_FFFF_0000_0000;
            else                in_data = lcg;
            #1;
            monitor_cycle();
            drive_cycle();
            if (cyc > 5000) begin
                check(1'b0, "R7", 64'(got), 64'(sent));
                break;
            end
        end
        check(got == 3 * NN, "R7", 64'(got), 64'(3 * NN));
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule